// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block sits in front of a true dual-port memory array. It watches the left and right ports. When both ports are enabled and point at the same word, it gives the word to one port and raises a busy flag toward the other. It also hands each port a qualified write enable, and the array uses that enable in place of the raw write strobe.

A mode pin chooses between two roles. As a master, the block makes the decision itself and drives the result on its busy outputs. As a slave, it keeps its busy outputs low and takes the verdict from busy inputs supplied by a master. The slave then uses those inputs to block writes. Several arrays can be placed side by side to widen the word: one master decides, and every slave obeys the same result.

Top module: `dp_busy_arb`

## Requirements
- R1: In master mode, a busy output can rise only when both ports were enabled and their addresses were equal in the previous clock. Busy appears one clock after such a match is first seen. Enables are active high.
- R2: In master mode, every clock that follows a matching clock shows exactly one busy output high. Busy outputs are never both high.
- R3: A port counts as "earlier" if it was enabled at the same address in the clock before the match began and the other port was not. When a match begins and exactly one port is earlier, that port wins. The busy flag goes to the other port.
- R4: If neither port is earlier when a match begins, the winner comes from an alternating toggle. The first such tie after reset goes to the left port, so busy_r is raised. Each tie flips the toggle.
- R5: The winner does not change while the match lasts. Busy drops one clock after the match ends, that is, after either port disables or the addresses differ.
- R6: In master mode, wr_ok_x equals en_x AND we_x AND NOT busy_x. The winner's writes and writes with no contention pass through. The loser's write is held off while its busy is high.
- R7: In slave mode (ms_mode low), busy_l and busy_r are driven low. wr_ok_x equals en_x AND we_x AND NOT busy_in_x.
- R8: In master mode, busy_in_l and busy_in_r have no effect on any output.
- R9: While reset is active, and in the first clock after it, both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_mode | input | 1 | 1 = master (decides and drives busy), 0 = slave (uses busy inputs) |
| en_l | input | 1 | Left port enable |
| we_l | input | 1 | Left port write strobe |
| addr_l | input | AW | Left port word address |
| en_r | input | 1 | Right port enable |
| we_r | input | 1 | Right port write strobe |
| addr_r | input | AW | Right port word address |
| busy_in_l | input | 1 | Verdict from master for left port (slave mode) |
| busy_in_r | input | 1 | Verdict from master for right port (slave mode) |
| wr_ok_l | output | 1 | Qualified left write enable to the array |
| wr_ok_r | output | 1 | Qualified right write enable to the array |
| busy_l | output | 1 | Left port lost arbitration (master mode) |
| busy_r | output | 1 | Right port lost arbitration (master mode) |

## Verification
The properties assume the port inputs stay idle while reset is held. They also assume that ms_mode changes only on clock boundaries. The stimulus drives every input on the falling edge, holds enables low through reset, and changes the mode only on idle cycles. Contention is built so that each kind of match start is covered: left earlier, right earlier, and a same-clock tie. Each kind is then ended by a disable, so the winner and the clearing clock can be predicted from the requirements alone.

// File: rtl/dp_busy_arb.sv
module dp_busy_arb #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_mode,
  input  logic          en_l,
  input  logic          we_l,
  input  logic [AW-1:0] addr_l,
  input  logic          en_r,
  input  logic          we_r,
  input  logic [AW-1:0] addr_r,
  input  logic          busy_in_l,
  input  logic          busy_in_r,
  output logic          wr_ok_l,
  output logic          wr_ok_r,
  output logic          busy_l,
  output logic          busy_r
);

  logic          prev_en_l, prev_en_r;
  logic [AW-1:0] prev_addr_l, prev_addr_r;
  logic          active_q, win_r_q, toggle_q;
  logic          bsy_l_q, bsy_r_q;

  logic match, fresh, held_l, held_r, tie, pick_r, win_r;

  assign match  = en_l && en_r && (addr_l == addr_r);
  assign fresh  = match && !active_q;
  assign held_l = en_l && prev_en_l && (addr_l == prev_addr_l);
  assign held_r = en_r && prev_en_r && (addr_r == prev_addr_r);
  assign tie    = held_l == held_r;
  assign pick_r = tie ? toggle_q : held_r;
  assign win_r  = fresh ? pick_r : win_r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_l   <= 1'b0;
      prev_en_r   <= 1'b0;
      prev_addr_l <= '0;
      prev_addr_r <= '0;
      active_q    <= 1'b0;
      win_r_q     <= 1'b0;
      toggle_q    <= 1'b0;
      bsy_l_q     <= 1'b0;
      bsy_r_q     <= 1'b0;
    end else begin
      prev_en_l   <= en_l;
      prev_en_r   <= en_r;
      prev_addr_l <= addr_l;
      prev_addr_r <= addr_r;
      active_q    <= match;
      win_r_q     <= win_r;
      if (fresh && tie) toggle_q <= ~toggle_q;
      bsy_l_q     <= match && win_r;
      bsy_r_q     <= match && !win_r;
    end
  end

  logic blk_l, blk_r;
  assign blk_l = ms_mode ? bsy_l_q : busy_in_l;
  assign blk_r = ms_mode ? bsy_r_q : busy_in_r;

  assign busy_l  = ms_mode && bsy_l_q;
  assign busy_r  = ms_mode && bsy_r_q;
  assign wr_ok_l = en_l && we_l && !blk_l;
  assign wr_ok_r = en_r && we_r && !blk_r;

endmodule

module dp_busy_arb_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_mode,
  input logic          en_l,
  input logic          we_l,
  input logic [AW-1:0] addr_l,
  input logic          en_r,
  input logic          we_r,
  input logic [AW-1:0] addr_r,
  input logic          busy_in_l,
  input logic          busy_in_r,
  input logic          wr_ok_l,
  input logic          wr_ok_r,
  input logic          busy_l,
  input logic          busy_r
);

  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ms_mode && (busy_l || busy_r) |-> $past(en_l && en_r && addr_l == addr_r));

  a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_l, busy_r}));

  a_r2_match_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ms_mode && $past(rst_n) && $past(en_l && en_r && addr_l == addr_r) |-> busy_l || busy_r);

  a_r5_keep_left_loser: assert property (@(posedge clk) disable iff (!rst_n)
    ms_mode && $past(busy_l) |-> !busy_r);

  a_r5_keep_right_loser: assert property (@(posedge clk) disable iff (!rst_n)
    ms_mode && $past(busy_r) |-> !busy_l);

  a_r6_block_l: assert property (@(posedge clk) disable iff (!rst_n)
    ms_mode && busy_l |-> !wr_ok_l);

  a_r6_block_r: assert property (@(posedge clk) disable iff (!rst_n)
    ms_mode && busy_r |-> !wr_ok_r);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_l |-> en_l && we_l) and (wr_ok_r |-> en_r && we_r));

  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_mode |-> !busy_l && !busy_r);

  a_r7_slave_block: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_mode && (busy_in_l || busy_in_r) |-> !(busy_in_l && wr_ok_l) && !(busy_in_r && wr_ok_r));

endmodule

bind dp_busy_arb dp_busy_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_mode(ms_mode),
  .en_l(en_l), .we_l(we_l), .addr_l(addr_l),
  .en_r(en_r), .we_r(we_r), .addr_r(addr_r),
  .busy_in_l(busy_in_l), .busy_in_r(busy_in_r),
  .wr_ok_l(wr_ok_l), .wr_ok_r(wr_ok_r),
  .busy_l(busy_l), .busy_r(busy_r)
);

// File: tb/dp_busy_arb_test.sv
module dp_busy_arb_test;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_mode = 1'b1;
  logic en_l = 0, we_l = 0, en_r = 0, we_r = 0;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic busy_in_l = 0, busy_in_r = 0;
  logic wr_ok_l, wr_ok_r, busy_l, busy_r;

  always #4 clk = ~clk;

  dp_busy_arb #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ms_mode(ms_mode),
    .en_l(en_l), .we_l(we_l), .addr_l(addr_l),
    .en_r(en_r), .we_r(we_r), .addr_r(addr_r),
    .busy_in_l(busy_in_l), .busy_in_r(busy_in_r),
    .wr_ok_l(wr_ok_l), .wr_ok_r(wr_ok_r),
    .busy_l(busy_l), .busy_r(busy_r)
  );

  typedef struct {
    logic  bl, br, wl, wr;
    string tag;
  } exp_t;

  exp_t sb[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic step(input logic ms, input logic el, input logic wl, input int al,
                      input logic er, input logic wr, input int ar,
                      input logic bil, input logic bir,
                      input logic xbl, input logic xbr, input logic xwl, input logic xwr,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ms_mode = ms; en_l = el; we_l = wl; addr_l = AW'(al);
    en_r = er; we_r = wr; addr_r = AW'(ar);
    busy_in_l = bil; busy_in_r = bir;
    e.bl = xbl; e.br = xbr; e.wl = xwl; e.wr = xwr; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input logic ms, input logic xbl, input logic xbr, input string tag);
    step(ms, 0, 0, 0, 0, 0, 0, 0, 0, xbl, xbr, 0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compared++;
        if ({busy_l, busy_r, wr_ok_l, wr_ok_r} !== {e.bl, e.br, e.wl, e.wr}) begin
          mismatched++;
          $display("FAIL %s: got busy_l/busy_r/wr_ok_l/wr_ok_r=%b%b%b%b expected %b%b%b%b",
                   e.tag, busy_l, busy_r, wr_ok_l, wr_ok_r, e.bl, e.br, e.wl, e.wr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (busy_l !== 1'b0 || busy_r !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 in reset: got %b%b expected 00", busy_l, busy_r);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(1, 0, 0, "R9 after reset");

    // R3: left earlier
    step(1, 1,0,5, 0,0,0, 0,0, 0,0,0,0, "R3 left alone");
    step(1, 1,0,5, 1,1,5, 0,0, 0,0,0,1, "R1 busy not yet raised");
    step(1, 1,0,5, 1,1,5, 0,0, 0,1,0,0, "R3 right busy, R6 blocked");
    step(1, 1,1,5, 1,1,5, 0,0, 0,1,1,0, "R6 winner writes");
    step(1, 0,0,5, 1,1,5, 0,0, 0,1,0,0, "R5 busy lingers one clock");
    step(1, 0,0,5, 1,1,5, 0,0, 0,0,0,1, "R5 busy cleared");
    idle(1, 0, 0, "R5 idle");

    // R3: right earlier
    step(1, 0,0,9, 1,0,9, 0,0, 0,0,0,0, "R3 right alone");
    step(1, 1,1,9, 1,0,9, 0,0, 0,0,1,0, "R1 left joins");
    step(1, 1,1,9, 1,0,9, 0,0, 1,0,0,0, "R3 left busy");
    idle(1, 1, 0, "R5 left busy lingers");
    idle(1, 0, 0, "R5 left busy cleared");

    // R4: ties alternate
    step(1, 1,1,3, 1,1,3, 0,0, 0,0,1,1, "R4 first tie start");
    step(1, 1,1,3, 1,1,3, 0,0, 0,1,1,0, "R4 first tie left wins");
    idle(1, 0, 1, "R5 tie release");
    idle(1, 0, 0, "R5 tie cleared");
    step(1, 1,1,3, 1,1,3, 0,0, 0,0,1,1, "R4 second tie start");
    step(1, 1,1,3, 1,1,3, 0,0, 1,0,0,1, "R4 second tie right wins");
    idle(1, 1, 0, "R5 second release");
    idle(1, 0, 0, "R5 second cleared");

    // R1: no match cases
    step(1, 1,1,1, 1,1,2, 0,0, 0,0,1,1, "R1 different addresses");
    step(1, 1,1,1, 1,1,2, 0,0, 0,0,1,1, "R1 different addresses held");
    step(1, 1,1,2, 0,1,2, 0,0, 0,0,1,0, "R1 right disabled same address");
    step(1, 1,1,2, 0,1,2, 0,0, 0,0,1,0, "R1 right disabled held");
    idle(1, 0, 0, "R1 idle");

    // R8: master ignores busy inputs
    step(1, 1,1,4, 1,1,8, 1,1, 0,0,1,1, "R8 busy_in ignored");
    step(1, 1,1,4, 1,1,8, 1,1, 0,0,1,1, "R8 busy_in ignored again");
    idle(1, 0, 0, "R8 idle");

    // R7: slave
    idle(0, 0, 0, "R7 slave idle");
    step(0, 1,1,4, 1,1,7, 1,0, 0,0,0,1, "R7 busy_in_l blocks left");
    step(0, 1,1,6, 1,1,6, 0,0, 0,0,1,1, "R7 contention no local busy");
    step(0, 1,1,6, 1,1,6, 0,0, 0,0,1,1, "R7 slave outputs low");
    step(0, 1,1,6, 1,1,6, 0,1, 0,0,1,0, "R7 busy_in_r blocks right");
    idle(0, 0, 0, "R7 slave release");
    idle(1, 0, 0, "R7 back to master");

    @(negedge clk);
    @(negedge clk);
    #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule